// File: doc/BRIEF.md
# Bus Cycle Break Condition Matcher

This block sits beside a processor's bus and compares every bus cycle against a break condition that software has programmed. When a cycle satisfies the condition, the block raises a break interrupt request for one clock and sets a sticky status flag. The condition combines a masked address compare with three two-bit selectors: cycle class (instruction fetch or data access), transfer direction (read or write) and operand size.

Software programs a compare address, an address mask and a control word through a single write port. It clears the status flag through the same port. Instruction fetches are always compared as word-sized. Data accesses use the size code that the requester presents, whatever the width of the memory being addressed. A write to the control word never affects the bus cycle presented in the same clock. That cycle is judged with the settings that applied before the write.

Top module: `bus_break_matcher`

## Requirements
- R1: After reset the compare address, the mask and the control word are all zero, and `brk_req_o` and `brk_flag_o` are low. With the reset control word, no bus cycle produces a request.
- R2: Control bits [5:4] select the cycle class. 00 means never break, 01 means fetch cycles only (`bus_fetch_i`=1), 10 means data cycles only, 11 means both.
- R3: Control bits [3:2] select the direction. 00 means never break, 01 means reads only (`bus_write_i`=0), 10 means writes only, 11 means both.
- R4: Control bits [1:0] select the size. 00 ignores size, 01 needs a byte, 10 needs a word, 11 needs a longword. A data cycle is compared using `bus_size_i`, which uses the same codes.
- R5: A fetch cycle is compared as a word whatever `bus_size_i` holds. A size selector of 01 or 11 therefore never matches a fetch.
- R6: An address bit takes part in the compare only when the mask bit in the same position is 0. A mask bit of 1 excludes that address bit.
- R7: `brk_req_o` is high in exactly the clock that follows a cycle with `bus_valid_i`=1 and every condition met. It is low after any other cycle.
- R8: A match sets `brk_flag_o`, and the flag holds until a port write with select 11 and data bit 0 = 1. When a match and such a clear fall in the same clock, the match wins and the flag stays set.
- R9: A port write with select 00 loads the compare address, select 01 loads the mask and select 10 loads control bits [5:0]. The write takes effect from the following clock. A bus cycle in the clock of the write is judged with the old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 2 | Write target: 00 address, 01 mask, 10 control, 11 flag clear |
| cfg_wdata_i | input | AW | Write data |
| bus_valid_i | input | 1 | A bus cycle is present this clock |
| bus_addr_i | input | AW | Bus cycle address |
| bus_fetch_i | input | 1 | 1 for instruction fetch, 0 for data access |
| bus_write_i | input | 1 | 1 for write, 0 for read |
| bus_size_i | input | 2 | Data operand size: 01 byte, 10 word, 11 longword |
| brk_req_o | output | 1 | One-clock break request |
| brk_flag_o | output | 1 | Sticky break status |

## Verification
The assertions check four things on every cycle. A zero class or direction selector, or a byte or longword size selector on a fetch, never produces a request. A request always comes with the flag set. The flag drops only after a clear write, and a match together with a clear leaves it set. Other behaviour is shown only by the bench's scenarios against its reference model. This covers the masked address compare, the use of old settings for a cycle that coincides with a control write, and the exact one-clock timing of the request. The same holds for the mapping of the data size codes.

// File: rtl/brk_pkg.sv
package brk_pkg;
  typedef enum logic [1:0] {
    SEL_ADDR = 2'b00,
    SEL_MASK = 2'b01,
    SEL_CTRL = 2'b10,
    SEL_CLR  = 2'b11
  } cfg_sel_e;

  typedef struct packed {
    logic [1:0] cls;  // [5:4]
    logic [1:0] dir;  // [3:2]
    logic [1:0] sz;   // [1:0]
  } brk_ctrl_t;

  localparam int          CTRL_W  = $bits(brk_ctrl_t);
  localparam logic [1:0]  SZ_ANY  = 2'b00;
  localparam logic [1:0]  SZ_WORD = 2'b10;
endpackage

// File: rtl/brk_regs.sv
module brk_regs
  import brk_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [1:0]    sel_i,
  input  logic [AW-1:0] wdata_i,
  output logic [AW-1:0] bar_o,
  output logic [AW-1:0] mask_o,
  output brk_ctrl_t     ctrl_o,
  output logic          clr_o
);
  logic [AW-1:0] bar_q, mask_q;
  brk_ctrl_t     ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bar_q  <= '0;
      mask_q <= '0;
      ctrl_q <= '0;
    end else if (we_i) begin
      unique case (cfg_sel_e'(sel_i))
        SEL_ADDR: bar_q  <= wdata_i;
        SEL_MASK: mask_q <= wdata_i;
        SEL_CTRL: ctrl_q <= brk_ctrl_t'(wdata_i[CTRL_W-1:0]);
        default:  ;
      endcase
    end
  end

  assign clr_o  = we_i && (cfg_sel_e'(sel_i) == SEL_CLR) && wdata_i[0];
  assign bar_o  = bar_q;
  assign mask_o = mask_q;
  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/brk_cond.sv
module brk_cond
  import brk_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0] bar_i,
  input  logic [AW-1:0] mask_i,
  input  brk_ctrl_t     ctrl_i,
  input  logic          valid_i,
  input  logic [AW-1:0] addr_i,
  input  logic          fetch_i,
  input  logic          write_i,
  input  logic [1:0]    size_i,
  output logic          hit_o
);
  logic [AW-1:0] bit_ok;
  logic [1:0]    eff_size;
  logic          cls_ok, dir_ok, size_ok, addr_ok;

  for (genvar g = 0; g < AW; g++) begin : g_abit
    assign bit_ok[g] = mask_i[g] | ~(addr_i[g] ^ bar_i[g]);
  end

  always_comb begin
    eff_size = fetch_i ? SZ_WORD : size_i;  // fetches compare as word
    cls_ok   = fetch_i ? ctrl_i.cls[0] : ctrl_i.cls[1];
    dir_ok   = write_i ? ctrl_i.dir[1] : ctrl_i.dir[0];
    size_ok  = (ctrl_i.sz == SZ_ANY) || (ctrl_i.sz == eff_size);
    addr_ok  = &bit_ok;
    hit_o    = valid_i && cls_ok && dir_ok && size_ok && addr_ok;
  end
endmodule

// File: rtl/brk_flag.sv
module brk_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic clr_i,
  output logic req_o,
  output logic flag_o
);
  logic req_q, flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      req_q <= hit_i;
      if (hit_i)      flag_q <= 1'b1;  // set beats clear
      else if (clr_i) flag_q <= 1'b0;
    end
  end

  assign req_o  = req_q;
  assign flag_o = flag_q;

  AST_FLAG_DROP_NEEDS_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_q) |-> $past(clr_i)) else $error("flag dropped without clear"); // R8
  AST_SET_BEATS_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && clr_i) |=> flag_q) else $error("clear beat a match"); // R8
endmodule

// File: rtl/bus_break_matcher.sv
module bus_break_matcher
  import brk_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [1:0]    cfg_sel_i,
  input  logic [AW-1:0] cfg_wdata_i,
  input  logic          bus_valid_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic          bus_fetch_i,
  input  logic          bus_write_i,
  input  logic [1:0]    bus_size_i,
  output logic          brk_req_o,
  output logic          brk_flag_o
);
  logic [AW-1:0] bar, mask;
  brk_ctrl_t     ctrl;
  logic          clr, hit;

  brk_regs #(.AW(AW)) u_regs (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .sel_i(cfg_sel_i), .wdata_i(cfg_wdata_i),
    .bar_o(bar), .mask_o(mask), .ctrl_o(ctrl), .clr_o(clr)
  );

  brk_cond #(.AW(AW)) u_cond (
    .bar_i(bar), .mask_i(mask), .ctrl_i(ctrl),
    .valid_i(bus_valid_i), .addr_i(bus_addr_i), .fetch_i(bus_fetch_i),
    .write_i(bus_write_i), .size_i(bus_size_i), .hit_o(hit)
  );

  brk_flag u_flag (
    .clk_i, .rst_ni, .hit_i(hit), .clr_i(clr),
    .req_o(brk_req_o), .flag_o(brk_flag_o)
  );

  AST_CLS_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl.cls == 2'b00) |=> !brk_req_o) else $error("break with class off"); // R2
  AST_DIR_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl.dir == 2'b00) |=> !brk_req_o) else $error("break with direction off"); // R3
  AST_FETCH_ODD_SIZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_fetch_i && ctrl.sz[0]) |=> !brk_req_o) else $error("fetch matched byte/long"); // R5
  AST_IDLE_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_valid_i |=> !brk_req_o) else $error("request without cycle"); // R7
  AST_REQ_HAS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_req_o |-> brk_flag_o) else $error("request without flag"); // R8
endmodule

// File: tb/bus_break_matcher_test.sv
`timescale 1ns/1ps
module bus_break_matcher_test;
  localparam int AW = 32;

  logic          clk = 1'b0, rst_ni = 1'b0;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_sel = '0;
  logic [AW-1:0] cfg_wdata = '0;
  logic          bus_valid = 1'b0, bus_fetch = 1'b0, bus_write = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [1:0]    bus_size = '0;
  logic          brk_req, brk_flag;

  int unsigned checks = 0, failures = 0;

  // reference state
  logic [AW-1:0] m_bar = '0, m_mask = '0;
  logic [5:0]    m_ctl = '0;
  logic          m_flag = 1'b0;

  always #2 clk = ~clk;

  bus_break_matcher #(.AW(AW)) uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_wdata_i(cfg_wdata),
    .bus_valid_i(bus_valid), .bus_addr_i(bus_addr), .bus_fetch_i(bus_fetch),
    .bus_write_i(bus_write), .bus_size_i(bus_size),
    .brk_req_o(brk_req), .brk_flag_o(brk_flag)
  );

  function automatic logic exp_hit(input logic v, input logic f, input logic w,
                                   input logic [1:0] s, input logic [AW-1:0] a);
    logic [1:0] es;
    logic c_ok, d_ok, s_ok, a_ok;
    es   = f ? 2'b10 : s;
    c_ok = f ? m_ctl[4] : m_ctl[5];
    d_ok = w ? m_ctl[3] : m_ctl[2];
    s_ok = (m_ctl[1:0] == 2'b00) || (m_ctl[1:0] == es);
    a_ok = (((a ^ m_bar) & ~m_mask) == '0);
    return v && c_ok && d_ok && s_ok && a_ok;
  endfunction

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s act=%0b exp=%0b", tag, what, act, exp);
    end
  endtask

  // one clock: drive at negedge, check outputs at the next negedge
  task automatic step(input string tag, input logic we, input logic [1:0] sel,
                      input logic [AW-1:0] wd, input logic v, input logic f,
                      input logic w, input logic [1:0] s, input logic [AW-1:0] a);
    logic eh, clr;
    cfg_we = we; cfg_sel = sel; cfg_wdata = wd;
    bus_valid = v; bus_fetch = f; bus_write = w; bus_size = s; bus_addr = a;
    eh  = exp_hit(v, f, w, s, a);
    clr = we && (sel == 2'b11) && wd[0];
    @(posedge clk);
    if (we) begin
      case (sel)
        2'b00: m_bar  = wd;
        2'b01: m_mask = wd;
        2'b10: m_ctl  = wd[5:0];
        default: ;
      endcase
    end
    if (eh) m_flag = 1'b1;
    else if (clr) m_flag = 1'b0;
    @(negedge clk);
    chk(tag, "brk_req", brk_req, eh);
    chk(tag, "brk_flag", brk_flag, m_flag);
  endtask

  task automatic wr(input string tag, input logic [1:0] sel, input logic [AW-1:0] wd);
    step(tag, 1'b1, sel, wd, 1'b0, 1'b0, 1'b0, 2'b00, '0);
  endtask

  task automatic cyc(input string tag, input logic f, input logic w,
                     input logic [1:0] s, input logic [AW-1:0] a);
    step(tag, 1'b0, 2'b00, '0, 1'b1, f, w, s, a);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "req in reset", brk_req, 1'b0);
    chk("R1", "flag in reset", brk_flag, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk);
    cyc("R1", 1'b0, 1'b0, 2'b10, '0);      // address 0 matches, ctrl zero
    cyc("R1", 1'b1, 1'b0, 2'b10, '0);

    // R9: register programming
    wr("R9", 2'b00, 32'h0000_1000);
    wr("R9", 2'b01, 32'h0);
    wr("R9", 2'b10, 32'h3C);               // cls 11 dir 11 sz any
    cyc("R7", 1'b0, 1'b0, 2'b11, 32'h0000_1000);
    step("R7", 1'b0, 2'b00, '0, 1'b0, 1'b0, 1'b0, 2'b00, 32'h0000_1000);
    cyc("R6", 1'b0, 1'b1, 2'b01, 32'h0000_1001);
    wr("R8", 2'b11, 32'h0);                // bit0 = 0: no clear
    wr("R8", 2'b11, 32'h1);                // clear
    step("R8", 1'b1, 2'b11, 32'h1, 1'b1, 1'b0, 1'b0, 2'b10, 32'h0000_1000);

    // R6 mask
    wr("R6", 2'b01, 32'h0000_000F);
    cyc("R6", 1'b0, 1'b0, 2'b10, 32'h0000_100A);
    cyc("R6", 1'b0, 1'b0, 2'b10, 32'h0000_1010);

    // R2 class
    wr("R2", 2'b10, 32'h1C);               // fetch only
    cyc("R2", 1'b1, 1'b0, 2'b00, 32'h0000_1000);
    cyc("R2", 1'b0, 1'b0, 2'b10, 32'h0000_1000);
    wr("R2", 2'b10, 32'h2C);               // data only
    cyc("R2", 1'b1, 1'b0, 2'b10, 32'h0000_1000);
    cyc("R2", 1'b0, 1'b1, 2'b10, 32'h0000_1000);

    // R3 direction
    wr("R3", 2'b10, 32'h34);               // reads only
    cyc("R3", 1'b0, 1'b1, 2'b10, 32'h0000_1000);
    cyc("R3", 1'b0, 1'b0, 2'b10, 32'h0000_1000);
    wr("R3", 2'b10, 32'h38);               // writes only
    cyc("R3", 1'b0, 1'b0, 2'b10, 32'h0000_1000);
    cyc("R3", 1'b0, 1'b1, 2'b10, 32'h0000_1000);
    wr("R3", 2'b10, 32'h30);               // dir off
    cyc("R3", 1'b0, 1'b1, 2'b10, 32'h0000_1000);

    // R4 / R5 sizes
    wr("R4", 2'b10, 32'h3D);               // byte
    cyc("R4", 1'b0, 1'b0, 2'b01, 32'h0000_1000);
    cyc("R4", 1'b0, 1'b0, 2'b11, 32'h0000_1000);
    cyc("R5", 1'b1, 1'b0, 2'b01, 32'h0000_1000);
    wr("R4", 2'b10, 32'h3F);               // longword
    cyc("R4", 1'b0, 1'b0, 2'b11, 32'h0000_1000);
    cyc("R5", 1'b1, 1'b0, 2'b11, 32'h0000_1000);
    wr("R5", 2'b10, 32'h3E);               // word
    cyc("R5", 1'b1, 1'b0, 2'b01, 32'h0000_1000);
    cyc("R4", 1'b0, 1'b0, 2'b01, 32'h0000_1000);

    // R9: write in same clock as a matching cycle uses old ctrl
    wr("R9", 2'b10, 32'h3C);
    step("R9", 1'b1, 2'b10, 32'h00, 1'b1, 1'b0, 1'b0, 2'b10, 32'h0000_1000);
    cyc("R9", 1'b0, 1'b0, 2'b10, 32'h0000_1000);
    step("R9", 1'b1, 2'b00, 32'h0000_2000, 1'b1, 1'b0, 1'b0, 2'b10, 32'h0000_2000);

    // random
    begin
      void'($urandom(32'hB5E7));
      for (int i = 0; i < 1500; i++) begin
        logic [AW-1:0] a;
        logic we;
        logic [1:0] sel;
        logic [AW-1:0] wd;
        we  = ($urandom_range(0, 7) == 0);
        sel = 2'($urandom_range(0, 3));
        wd  = $urandom();
        if (we && sel == 2'b01) wd = wd & 32'h0000_00FF;
        a = ($urandom_range(0, 1) != 0) ? (m_bar ^ ($urandom() & m_mask)) : 32'($urandom());
        step("R7 R8", we, sel, wd, 1'($urandom_range(0, 3) != 0), 1'($urandom()),
             1'($urandom()), 2'($urandom()), a);
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 4);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule